// File: doc/BRIEF.md
# Midplane Status and Hot-Swap Register File

This block is a small register file on the controller that sits on a chassis midplane. A host reaches it over a byte-offset register bus with separate read and write strobes. It gives the host four things. The first is a power-good word that shows which adapter bays have both supply rails up. The second is a general control word. The third is a sticky event register that catches hot insertion and removal pulses for slots 1 to 6, plus an SRAM error pulse. The fourth is a masked view of the power word, which management software reads when an adapter-management interrupt comes in.

The block drives two interrupt lines. The event interrupt rises on any hot-swap or SRAM event. Any access to the event register drops it. The management interrupt rises on a request input and falls only when the host reads the masked power view. Read data is registered. Some offsets read as fixed patterns or accept writes that are thrown away. These exist so that the host's polling and housekeeping accesses complete without side effects.

Top module: `mp_status_regs`

## Requirements
- R1: Offset 0x50 reads the power word. Each bay owns two adjacent bits, and both read 1 when the bay is powered. The low bit of each pair is at: bay0 bit 1, bay1 bit 9, bay2 bit 13, bay3 bit 25, bay4 bit 17, bay5 bit 29, bay6 bit 21. All other bits read 0. Bay 0 is always powered. Bay k (1..6) is powered only while `bay_present[k-1]` is 1.
- R2: A read at offset 0x40 returns the power word ANDed with 0x66666600.
- R3: `mgmt_req` high sets `mgmt_irq` from the next cycle. Only a read at offset 0x40 clears it. If a request and that read fall in the same cycle, the interrupt stays set.
- R4: Offset 0x70 is the event register. Bit k (1..6) is set by a pulse on `oir_event[k-1]`, and bit 7 is set by `sram_err`. Bits 0 and 31..8 read 0. Any such pulse also sets `oir_irq` from the next cycle.
- R5: A read at offset 0x70 clears `oir_irq` and leaves the event bits unchanged.
- R6: A write at offset 0x70 clears every event bit written as 1, keeps the others, and clears `oir_irq`.
- R7: If an event pulse and a write or read at offset 0x70 fall in the same cycle, the pulsed bit ends set and `oir_irq` ends set.
- R8: Offset 0x58 is a 32-bit control word that can be read and written. It resets to 0.
- R9: Offset 0x48 reads all ones and offset 0x78 reads 0. Writes to offsets 0x78, 0x38 and 0x7B change nothing that can be read back.
- R10: Any offset not named in R1 to R9 reads 0 and ignores writes. Writes to the read-only offsets 0x40, 0x48 and 0x50 are also ignored.
- R11: `bus_rdata` loads on the clock edge that samples `bus_rd` and holds until the next read. The value is the register state just before that edge.
- R12: After reset, `bus_rdata`, `oir_irq`, `mgmt_irq`, the event bits and the control word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bay_present | input | 6 | Presence of bays 1..6, bit k-1 for bay k |
| oir_event | input | 6 | Hot-swap event pulses for slots 1..6 |
| sram_err | input | 1 | SRAM error pulse |
| mgmt_req | input | 1 | Management interrupt request |
| oir_irq | output | 1 | Event interrupt |
| mgmt_irq | output | 1 | Management interrupt |

## Verification
Two pairs of functions can collide in one cycle. One pair is an event pulse and a host access to the event register, either a write-one-to-clear or the read that drops the interrupt. The other pair is a management request and the masked-power read that clears it. The bench raises the pulse and the bus strobe on the same falling edge. One half-cycle after the next rising edge, it checks that the interrupt line is still high. It then reads the event register back to confirm that the pulsed bit survived the clear.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int BAY_COUNT  = 7;
  localparam int SLOT_COUNT = BAY_COUNT - 1;
  localparam int FLAG_W     = SLOT_COUNT + 2;
  localparam int SRAM_BIT   = SLOT_COUNT + 1;

  localparam logic [7:0] OFF_MGMT  = 8'h40;
  localparam logic [7:0] OFF_ONES  = 8'h48;
  localparam logic [7:0] OFF_POWER = 8'h50;
  localparam logic [7:0] OFF_CTRL  = 8'h58;
  localparam logic [7:0] OFF_EVENT = 8'h70;
  localparam logic [7:0] OFF_ZERO  = 8'h78;
  localparam logic [7:0] OFF_SINKA = 8'h38;
  localparam logic [7:0] OFF_SINKB = 8'h7B;

  localparam logic [31:0] MGMT_MASK = 32'h6666_6600;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MGMT,
    SEL_ONES,
    SEL_POWER,
    SEL_CTRL,
    SEL_EVENT,
    SEL_ZERO,
    SEL_SINK
  } reg_sel_e;

  // nibble holding a bay's rail pair; the pair sits at bits 4*n+1 and 4*n+2
  function automatic int rail_nibble(input int bay);
    case (bay)
      0:       rail_nibble = 0;
      1:       rail_nibble = 2;
      2:       rail_nibble = 3;
      3:       rail_nibble = 6;
      4:       rail_nibble = 4;
      5:       rail_nibble = 7;
      default: rail_nibble = 5;
    endcase
  endfunction

  function automatic int rail_lo_bit(input int bay);
    rail_lo_bit = 4 * rail_nibble(bay) + 1;
  endfunction
endpackage

// File: rtl/mp_addr_decode.sv
module mp_addr_decode
  import mp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr[ADDR_W-1:8] == '0) begin
      case (addr[7:0])
        OFF_MGMT:  sel = SEL_MGMT;
        OFF_ONES:  sel = SEL_ONES;
        OFF_POWER: sel = SEL_POWER;
        OFF_CTRL:  sel = SEL_CTRL;
        OFF_EVENT: sel = SEL_EVENT;
        OFF_ZERO:  sel = SEL_ZERO;
        OFF_SINKA: sel = SEL_SINK;
        OFF_SINKB: sel = SEL_SINK;
        default:   sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mp_power_map.sv
module mp_power_map
  import mp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SLOT_COUNT-1:0] present,
  output logic [DATA_W-1:0]     power_word
);
  logic [BAY_COUNT-1:0] powered;

  // bay 0 is hard-wired powered; the rest follow their presence bit
  assign powered = {present, 1'b1};

  always_comb begin
    power_word = '0;
    for (int b = 0; b < BAY_COUNT; b++) begin
      if (powered[b]) power_word[rail_lo_bit(b) +: 2] = 2'b11;
    end
  end

  // R1: a missing bay never reports power
  always_comb begin
    for (int b = 1; b < BAY_COUNT; b++) begin
      assert_absent_dark_R1: assert (present[b-1] || power_word[rail_lo_bit(b) +: 2] == 2'b00);
    end
  end
endmodule

// File: rtl/mp_event_latch.sv
module mp_event_latch
  import mp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SLOT_COUNT-1:0] slot_evt,
  input  logic                  sram_evt,
  input  logic                  acc_rd,
  input  logic                  acc_wr,
  input  logic [FLAG_W-1:0]     wdata,
  output logic [FLAG_W-1:0]     flags,
  output logic                  irq
);
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic              any_set;

  assign set_vec = {sram_evt, slot_evt, 1'b0};
  assign clr_vec = acc_wr ? wdata : '0;
  assign any_set = |set_vec;

  assign flags[0] = 1'b0;

  genvar k;
  generate
    for (k = 1; k < FLAG_W; k++) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)             bit_q <= 1'b0;
        else if (set_vec[k]) bit_q <= 1'b1;
        else if (clr_vec[k]) bit_q <= 1'b0;
      end
      assign flags[k] = bit_q;

      // R4 / R7: a pulse always leaves its bit set
      assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
        set_vec[k] |=> flags[k]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                  irq <= 1'b0;
    else if (any_set)         irq <= 1'b1;
    else if (acc_rd | acc_wr) irq <= 1'b0;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    any_set |=> irq);

  assert_read_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && !acc_wr && !any_set) |=> (!irq && $stable(flags)));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !any_set) |=> (!irq && (flags & $past(wdata)) == '0));
endmodule

// File: rtl/mp_mgmt_irq.sv
module mp_mgmt_irq (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (req) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  assert_mgmt_set_R3: assert property (@(posedge clk) disable iff (rst)
    req |=> irq);

  assert_mgmt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);
endmodule

// File: rtl/mp_status_regs.sv
module mp_status_regs
  import mp_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] CTRL_RESET = 32'h0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [SLOT_COUNT-1:0] bay_present,
  input  logic [SLOT_COUNT-1:0] oir_event,
  input  logic                  sram_err,
  input  logic                  mgmt_req,
  output logic                  oir_irq,
  output logic                  mgmt_irq
);
  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(MGMT_MASK);

  reg_sel_e          sel;
  logic [DATA_W-1:0] power_word;
  logic [DATA_W-1:0] ctrl_q;
  logic [FLAG_W-1:0] flags;
  logic [DATA_W-1:0] rd_mux;
  logic              evt_rd;
  logic              evt_wr;
  logic              mgmt_clr;

  mp_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  mp_power_map #(.DATA_W(DATA_W)) u_pwr (
    .present    (bay_present),
    .power_word (power_word)
  );

  assign evt_rd   = bus_rd && (sel == SEL_EVENT);
  assign evt_wr   = bus_wr && (sel == SEL_EVENT);
  assign mgmt_clr = bus_rd && (sel == SEL_MGMT);

  mp_event_latch u_evt (
    .clk      (clk),
    .rst      (rst),
    .slot_evt (oir_event),
    .sram_evt (sram_err),
    .acc_rd   (evt_rd),
    .acc_wr   (evt_wr),
    .wdata    (bus_wdata[FLAG_W-1:0]),
    .flags    (flags),
    .irq      (oir_irq)
  );

  mp_mgmt_irq u_mgmt (
    .clk (clk),
    .rst (rst),
    .req (mgmt_req),
    .clr (mgmt_clr),
    .irq (mgmt_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)                            ctrl_q <= DATA_W'(CTRL_RESET);
    else if (bus_wr && sel == SEL_CTRL) ctrl_q <= bus_wdata;
  end

  always_comb begin
    case (sel)
      SEL_MGMT:  rd_mux = power_word & MASK_W;
      SEL_ONES:  rd_mux = '1;
      SEL_POWER: rd_mux = power_word;
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_EVENT: rd_mux = DATA_W'(flags);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_ones_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_ONES)) |=> bus_rdata == '1);

  assert_mgmt_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_MGMT)) |=> (bus_rdata & ~MASK_W) == '0);

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0);

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_W'(OFF_CTRL)) |=> $stable(ctrl_q));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_mp_status_regs.sv
module sim_mp_status_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  bay_present = '0;
  logic [5:0]  oir_event = '0;
  logic        sram_err = 1'b0;
  logic        mgmt_req = 1'b0;
  logic        oir_irq;
  logic        mgmt_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mp_status_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bay_present(bay_present),
    .oir_event(oir_event), .sram_err(sram_err), .mgmt_req(mgmt_req),
    .oir_irq(oir_irq), .mgmt_irq(mgmt_irq)
  );

  // vector: {is_read, addr, data(write data or expected read), req tag}
  localparam int VEC_N = 17;
  localparam logic [44:0] VEC [VEC_N] = '{
    {1'b1, 8'h50, 32'h0066_6006, 4'd1},   // R1 bays 0,2,4,6 powered
    {1'b1, 8'h40, 32'h0066_6000, 4'd2},   // R2
    {1'b1, 8'h48, 32'hFFFF_FFFF, 4'd9},   // R9
    {1'b1, 8'h78, 32'h0000_0000, 4'd9},   // R9
    {1'b0, 8'h58, 32'hA5A5_5A5A, 4'd8},   // R8 write
    {1'b1, 8'h58, 32'hA5A5_5A5A, 4'd8},   // R8
    {1'b0, 8'h78, 32'hFFFF_FFFF, 4'd9},   // R9 sink write
    {1'b0, 8'h38, 32'hFFFF_FFFF, 4'd9},   // R9 sink write
    {1'b0, 8'h7B, 32'hFFFF_FFFF, 4'd9},   // R9 sink write
    {1'b1, 8'h58, 32'hA5A5_5A5A, 4'd9},   // R9 control untouched
    {1'b1, 8'h78, 32'h0000_0000, 4'd9},   // R9
    {1'b1, 8'h70, 32'h0000_0000, 4'd9},   // R9 events untouched
    {1'b0, 8'h11, 32'h0000_1234, 4'd10},  // R10 write unmapped
    {1'b1, 8'h11, 32'h0000_0000, 4'd10},  // R10
    {1'b1, 8'h58, 32'hA5A5_5A5A, 4'd10},  // R10
    {1'b0, 8'h50, 32'h0000_0000, 4'd10},  // R10 write read-only
    {1'b1, 8'h50, 32'h0066_6006, 4'd10}   // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 rdata", bus_rdata, 32'h0);
    check("R12 oir_irq", {31'h0, oir_irq}, 32'h0);
    check("R12 mgmt_irq", {31'h0, mgmt_irq}, 32'h0);
    bus_read(8'h58, rd); check("R12 ctrl", rd, 32'h0);
    bus_read(8'h70, rd); check("R12 events", rd, 32'h0);

    bay_present = 6'b101010;
    for (int i = 0; i < VEC_N; i++) begin
      if (VEC[i][44]) begin
        bus_read(VEC[i][43:36], rd);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
      end else begin
        bus_write(VEC[i][43:36], VEC[i][35:4]);
      end
    end

    // R1 / R2 other presence patterns
    bay_present = 6'h3F;
    bus_read(8'h50, rd); check("R1 all present", rd, 32'h6666_6606);
    bus_read(8'h40, rd); check("R2 all present", rd, 32'h6666_6600);
    bay_present = 6'h00;
    bus_read(8'h50, rd); check("R1 none present", rd, 32'h0000_0006);
    bus_read(8'h40, rd); check("R2 none present", rd, 32'h0);

    // R11 latency: rdata unchanged before the sampling edge, new after
    @(negedge clk);
    bus_addr = 8'h48; bus_rd = 1'b1;
    #1 check("R11 before edge", bus_rdata, 32'h0);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R11 after edge", bus_rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R11 hold", bus_rdata, 32'hFFFF_FFFF);

    // R4 slot event
    @(negedge clk); oir_event = 6'b000100;
    @(negedge clk); oir_event = '0;
    check("R4 oir_irq set", {31'h0, oir_irq}, 32'h1);
    bus_read(8'h70, rd); check("R4 slot3 bit", rd, 32'h08);
    check("R5 irq dropped by read", {31'h0, oir_irq}, 32'h0);
    bus_read(8'h70, rd); check("R5 bits kept", rd, 32'h08);
    @(negedge clk); sram_err = 1'b1;
    @(negedge clk); sram_err = 1'b0;
    check("R4 sram irq", {31'h0, oir_irq}, 32'h1);
    bus_read(8'h70, rd); check("R4 sram bit", rd, 32'h88);

    // R6 write one to clear
    @(negedge clk); oir_event = 6'b100001;
    @(negedge clk); oir_event = '0;
    bus_write(8'h70, 32'h0000_0008);
    check("R6 irq dropped by write", {31'h0, oir_irq}, 32'h0);
    bus_read(8'h70, rd); check("R6 selective clear", rd, 32'hC2);

    // R7 set wins over write clear
    @(negedge clk);
    bus_addr = 8'h70; bus_wdata = 32'hFF; bus_wr = 1'b1; sram_err = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sram_err = 1'b0;
    check("R7 irq after collide", {31'h0, oir_irq}, 32'h1);
    bus_read(8'h70, rd); check("R7 bit survives", rd, 32'h80);
    // R7 event with read of event register
    @(negedge clk);
    bus_addr = 8'h70; bus_rd = 1'b1; oir_event = 6'b000010;
    @(negedge clk);
    bus_rd = 1'b0; oir_event = '0;
    check("R7 read collide rdata", bus_rdata, 32'h80);
    check("R7 read collide irq", {31'h0, oir_irq}, 32'h1);

    // R3 management interrupt
    @(negedge clk); mgmt_req = 1'b1;
    @(negedge clk); mgmt_req = 1'b0;
    check("R3 mgmt set", {31'h0, mgmt_irq}, 32'h1);
    bus_read(8'h50, rd);
    bus_write(8'h40, 32'hFFFF_FFFF);
    check("R3 mgmt held", {31'h0, mgmt_irq}, 32'h1);
    bus_read(8'h40, rd);
    check("R3 mgmt cleared", {31'h0, mgmt_irq}, 32'h0);
    @(negedge clk);
    bus_addr = 8'h40; bus_rd = 1'b1; mgmt_req = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; mgmt_req = 1'b0;
    check("R3 req wins", {31'h0, mgmt_irq}, 32'h1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule